// File: doc/BRIEF.md
# Systolic Linear Sorting Array

The block sorts a short batch of unsigned words with a chain of identical compare cells that all run on one clock. Words enter the left end one per cycle. Every cell holds the smallest value it has seen so far and pushes the other value one cell to the right. An empty cell holds the all-ones code, which reads as "larger than anything", so the first real word that reaches an empty cell always settles there.

A batch ends on the first cycle after at least one word in which no word enters. That cycle can be an idle input or an explicit all-ones word. This empty slot follows the last word down the chain. When a cell sees a real value followed by this empty slot, it switches direction. It sends its stored word back to the left, and after that it relays whatever comes back from its right-hand neighbour. The smallest word therefore leaves the left end first, and the rest follow in ascending order, one every second cycle. Input is refused until the whole chain is empty again.

Top module: `lin_sort_array`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A word is taken in on a rising edge where `in_valid` and `in_ready` are both 1 and `in_data` is not all-ones. Legal words are 0 to 2^W−2, and a batch is up to N words on consecutive cycles.
- R3: A batch ends at the first edge after at least one accepted word in which no word is accepted, because `in_valid` is 0 or `in_data` is all-ones. `in_ready` is 0 from the next cycle until the drain completes.
- R4: While `in_ready` is 0, the values on `in_valid` and `in_data` have no effect, and no extra word appears on the output.
- R5: The words presented on the output are exactly the accepted words of the batch, duplicates included, in ascending order.
- R6: The smallest word is valid on the output in the cycle right after the ending edge. The word of rank k (counting from 0) is valid 2k cycles later, each for one cycle, with `out_valid` low in between.
- R7: After the last word of a batch, `in_ready` returns to 1 with `out_valid` low. The next batch is sorted with no trace of the previous one.
- R8: Cycles without an accepted word, while no word of a batch has yet been taken, start no drain: `in_ready` stays 1 and `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all cells |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word present on `in_data` |
| in_data | input | W | Input word. All-ones marks an empty slot. |
| in_ready | output | 1 | Array is accepting a batch |
| out_valid | output | 1 | `out_data` carries a sorted word |
| out_data | output | W | Word leaving the left end |

## Verification
The hardest condition to reach is a switch of direction that happens while words are still moving right deeper in the chain. That only happens when the batch ends right after words that keep displacing stored values, and most often with a full batch of N words in descending order. The stimulus mixes directed full-length descending, ascending and all-equal batches with random-length random batches. It also drives noise on the input for the whole drain to show that the input is ignored, and ends batches both with an idle cycle and with an explicit all-ones word.

// File: rtl/lin_sort_pkg.sv
package lin_sort_pkg;
  typedef enum logic {
    S_FILL  = 1'b0,
    S_DRAIN = 1'b1
  } cell_mode_t;
endpackage

// File: rtl/sort_cell.sv
module sort_cell
  import lin_sort_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] lft_in,
  input  logic [W-1:0] rgt_in,
  output logic [W-1:0] rgt_out,
  output logic [W-1:0] lft_out,
  output logic         empty
);
  localparam logic [W-1:0] EMPTY_CODE = '1;

  logic [W-1:0] stored;
  logic [W-1:0] to_r;
  logic [W-1:0] to_l;
  logic         seen;
  cell_mode_t   mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      stored <= EMPTY_CODE;
      to_r   <= EMPTY_CODE;
      to_l   <= EMPTY_CODE;
      seen   <= 1'b0;
      mode   <= S_FILL;
    end else begin
      case (mode)
        S_FILL: begin
          to_l <= EMPTY_CODE;
          if (lft_in != EMPTY_CODE) begin
            seen <= 1'b1;
            if (lft_in < stored) begin
              stored <= lft_in;
              to_r   <= stored;
            end else begin
              to_r <= lft_in;
            end
          end else begin
            to_r <= EMPTY_CODE;
            if (seen) begin
              mode   <= S_DRAIN;
              to_l   <= stored;
              stored <= EMPTY_CODE;
              seen   <= 1'b0;
            end
          end
        end
        default: begin
          to_r <= EMPTY_CODE;
          to_l <= rgt_in;
          if (clr) mode <= S_FILL;
        end
      endcase
    end
  end

  assign rgt_out = to_r;
  assign lft_out = to_l;
  assign empty   = (stored == EMPTY_CODE) && (to_l == EMPTY_CODE);
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         all_empty,
  output logic [W-1:0] feed,
  output logic         in_ready,
  output logic         clr
);
  localparam logic [W-1:0] EMPTY_CODE = '1;

  logic busy;
  logic got;

  assign feed = (in_valid && !busy) ? in_data : EMPTY_CODE;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      got  <= 1'b0;
    end else begin
      got <= (feed != EMPTY_CODE);
      if (!busy && got && feed == EMPTY_CODE) busy <= 1'b1;
      else if (busy && all_empty)             busy <= 1'b0;
    end
  end

  assign in_ready = !busy;
  assign clr      = busy && all_empty;
endmodule

// File: rtl/lin_sort_array.sv
module lin_sort_array #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam logic [W-1:0] EMPTY_CODE = '1;

  logic [W-1:0] rchain [N+1];
  logic [W-1:0] lchain [N+1];
  logic [N-1:0] cell_empty;
  logic [N-1:0] link_empty;
  logic         all_empty;
  logic         clr;

  sort_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .all_empty (all_empty),
    .feed      (rchain[0]),
    .in_ready  (in_ready),
    .clr       (clr)
  );

  assign lchain[N] = EMPTY_CODE;

  for (genvar i = 0; i < N; i++) begin : g_cell
    sort_cell #(.W(W)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .lft_in  (rchain[i]),
      .rgt_in  (lchain[i+1]),
      .rgt_out (rchain[i+1]),
      .lft_out (lchain[i]),
      .empty   (cell_empty[i])
    );
    assign link_empty[i] = (rchain[i+1] == EMPTY_CODE);
  end

  assign all_empty = (&cell_empty) && (&link_empty);
  assign out_data  = lchain[0];
  assign out_valid = (lchain[0] != EMPTY_CODE);
endmodule

// File: rtl/lin_sort_array_chk.sv
module lin_sort_array_chk #(
  parameter int N = 8,
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         in_ready,
  input logic         out_valid,
  input logic [W-1:0] out_data
);
  localparam logic [W-1:0] EMPTY_CODE = '1;

  logic        acc;
  logic        prev_acc;
  logic [15:0] pend;
  logic [W-1:0] last_out;
  logic        have_last;

  assign acc = in_valid && in_ready && (in_data != EMPTY_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_acc  <= 1'b0;
      pend      <= '0;
      last_out  <= '0;
      have_last <= 1'b0;
    end else begin
      prev_acc <= acc;
      pend     <= pend + 16'(acc) - 16'(out_valid);
      if (out_valid) begin
        last_out  <= out_data;
        have_last <= 1'b1;
      end else if (in_ready) begin
        have_last <= 1'b0;
      end
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (in_ready && !out_valid)); // R1
  AST_END_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (in_ready && prev_acc && !acc) |=> !in_ready); // R3
  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (out_valid && have_last) |-> (out_data >= last_out)); // R5
  AST_BALANCED: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> (pend == 16'd0)); // R5
  AST_SPACED_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R6
  AST_QUIET_READY: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid); // R7
endmodule

bind lin_sort_array lin_sort_array_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/sim_lin_sort_array.sv
`timescale 1ns/1ps
module sim_lin_sort_array;
  localparam int N = 8;
  localparam int W = 8;
  localparam logic [W-1:0] EMPTY_CODE = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready;
  logic         out_valid;
  logic [W-1:0] out_data;

  int errors = 0;
  int checks = 0;

  logic [W-1:0] w   [N];
  logic [W-1:0] e   [N];
  logic [W-1:0] got [2*N];
  int ng;

  always #2.5 clk = ~clk;

  lin_sort_array #(.N(N), .W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd_word();
    return int'($urandom % ((1 << W) - 1));
  endfunction

  task automatic run_batch(input int n, input bit sentinel, input bit noise);
    int cyc;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = w[i];
      @(negedge clk);
    end
    in_valid = sentinel;
    in_data  = EMPTY_CODE;
    @(negedge clk);
    in_valid = noise;
    in_data  = W'($urandom);
    chk(!in_ready, "R3", "in_ready after end", int'(in_ready), 0);
    ng  = 0;
    cyc = 0;
    forever begin
      if (out_valid) begin
        chk(cyc == 2 * ng, "R6", "output slot", cyc, 2 * ng);
        if (ng < 2 * N) got[ng] = out_data;
        ng++;
      end
      if (in_ready) begin
        in_valid = 1'b0;
        break;
      end
      if (cyc > 4 * N + 8) break;
      @(negedge clk);
      cyc++;
      if (noise) in_data = W'($urandom);
    end
    chk(in_ready, "R7", "ready back after drain", int'(in_ready), 1);
    for (int i = 0; i < n; i++) e[i] = w[i];
    for (int i = 1; i < n; i++)
      for (int j = i; j > 0 && e[j-1] > e[j]; j--) begin
        logic [W-1:0] t;
        t = e[j]; e[j] = e[j-1]; e[j-1] = t;
      end
    chk(ng == n, noise ? "R4" : "R5", "word count", ng, n);
    for (int i = 0; i < n && i < ng; i++)
      chk(got[i] == e[i], "R5", "sorted word", int'(got[i]), int'(e[i]));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!out_valid && in_ready, "R7", "quiet after drain", int'(out_valid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(in_ready && !out_valid, "R1", "reset state", int'({in_ready, out_valid}), 2);

    // R8: idle and all-ones slots with nothing taken start no drain
    for (int i = 0; i < 6; i++) begin
      in_valid = i[0];
      in_data  = EMPTY_CODE;
      @(negedge clk);
      chk(in_ready && !out_valid, "R8", "no drain without words",
          int'({in_ready, out_valid}), 2);
    end
    in_valid = 1'b0;

    // R2 R5: full batch descending, the deepest ripple
    for (int i = 0; i < N; i++) w[i] = W'((1 << W) - 2 - i);
    run_batch(N, 1'b0, 1'b0);
    // R2: ascending with the extreme legal values, ended by an all-ones word
    for (int i = 0; i < N; i++) w[i] = (i == N - 1) ? W'((1 << W) - 2) : W'(i);
    run_batch(N, 1'b1, 1'b0);
    // R5 duplicates kept
    for (int i = 0; i < N; i++) w[i] = W'(7);
    run_batch(N, 1'b0, 1'b1);
    // single word
    w[0] = '0;
    run_batch(1, 1'b1, 1'b1);
    // R4: noise during drain, random batches
    for (int b = 0; b < 25; b++) begin
      int n;
      n = 1 + int'($urandom % N);
      for (int i = 0; i < n; i++) w[i] = W'(rnd_word());
      run_batch(n, b[0], b[1]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule